// File: doc/BRIEF.md
# Return-Clock Agreement Voter

This block sits between one debug probe and several JTAG targets that each echo their test clock on a return-clock pin. The probe's test clock is fanned out to every return-clock-capable target at once, not passed down a chain. Each target's returned clock is watched, and one combined return clock goes back to the probe. The combined clock moves to a new level only when every target taking part in the vote has echoed the level the probe last drove. The clock rate therefore settles at the pace of the slowest target, and no series delay builds up from one target to the next.

A mask picks which targets take part, so empty sockets or idle parts drop out of the vote. Targets without a return-clock pin take their test clock from the combined return clock, so they never run ahead of the vote. The probe clock and all returned clocks are brought into a local sampling clock through synchronizer stages before they are compared.

Top module: `rtck_voter`

## Requirements
- R1: The probe test clock appears on every bit of `dev_tck` in the same cycle, with no register in the path.
- R2: After reset, `probe_rtck` and `plain_tck` are low.
- R3: `probe_rtck` rises only when the synchronized probe clock is high and every enabled returned clock is high. A high on all returned clocks while the probe clock is low leaves it low.
- R4: `probe_rtck` falls only when the synchronized probe clock is low and every enabled returned clock is low.
- R5: While any enabled target has not yet echoed the probe clock level, `probe_rtck` holds its level. The slowest target sets the pace.
- R6: A target whose `dev_en` bit is 0 has no effect on `probe_rtck`, whatever its returned clock does.
- R7: `plain_tck` equals `probe_rtck` at all times.
- R8: With `dev_en` all zero, `probe_rtck` follows the probe clock.
- R9: With two synchronizer stages, after `probe_tck` and all returned clocks change together before a sampling edge, `probe_rtck` is still unchanged one sampling edge later and has taken the new level within five sampling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_tck | input | 1 | Test clock from the probe |
| dev_en | input | N_DEV | Vote mask, 1 = target takes part |
| dev_rtck | input | N_DEV | Returned clocks from the targets |
| dev_tck | output | N_DEV | Test clock fanned out to return-clock targets |
| probe_rtck | output | 1 | Combined return clock to the probe |
| plain_tck | output | 1 | Test clock for targets without a return pin |

## Verification
On every cycle the assertions check that the combined clock rises only on a unanimous high vote under a high expected level, falls only on a unanimous low vote under a low expected level, and stays put while the enabled targets disagree. They also check that a non-empty mask never yields both votes at once. Only the bench scenarios can show the fan-out timing, that a masked target really has no effect, that the combined clock follows the probe clock with an empty mask, and the synchronizer latency window.

// File: rtl/rv_pkg.sv
package rv_pkg;

    typedef struct packed {
        logic expect_lvl;
        logic vote_out;
    } rv_state_t;

    localparam rv_state_t RV_RESET = '{expect_lvl: 1'b0, vote_out: 1'b0};

endpackage

// File: rtl/rv_sync.sv
module rv_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d_async;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    assign d_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/rv_vote.sv
module rv_vote #(
    parameter int N_DEV = 4
) (
    input  logic [N_DEV-1:0] en,
    input  logic [N_DEV-1:0] lvl,
    output logic             all_high,
    output logic             all_low
);
    logic [N_DEV-1:0] hi_ok;
    logic [N_DEV-1:0] lo_ok;

    for (genvar i = 0; i < N_DEV; i++) begin : g_lane
        assign hi_ok[i] = ~en[i] | lvl[i];
        assign lo_ok[i] = ~en[i] | ~lvl[i];
    end

    assign all_high = &hi_ok;
    assign all_low  = &lo_ok;
endmodule

// File: rtl/rtck_voter.sv
module rtck_voter #(
    parameter int N_DEV       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             probe_tck,
    input  logic [N_DEV-1:0] dev_en,
    input  logic [N_DEV-1:0] dev_rtck,
    output logic [N_DEV-1:0] dev_tck,
    output logic             probe_rtck,
    output logic             plain_tck
);
    import rv_pkg::*;

    localparam int SYNC_W = N_DEV + 1;

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] synced;
    logic              tck_s;
    logic [N_DEV-1:0]  rtck_s;
    logic              all_high;
    logic              all_low;

    rv_state_t st_d;
    rv_state_t st_q;

    // parallel fan-out of the probe clock to every return-clock target
    assign dev_tck = {N_DEV{probe_tck}};

    assign raw_in = {probe_tck, dev_rtck};

    rv_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .d_sync  (synced)
    );

    assign tck_s  = synced[SYNC_W-1];
    assign rtck_s = synced[N_DEV-1:0];

    rv_vote #(.N_DEV(N_DEV)) u_vote (
        .en       (dev_en),
        .lvl      (rtck_s),
        .all_high (all_high),
        .all_low  (all_low)
    );

    always_comb begin
        st_d            = st_q;
        st_d.expect_lvl = tck_s;
        if (st_q.expect_lvl && all_high) begin
            st_d.vote_out = 1'b1;
        end else if (!st_q.expect_lvl && all_low) begin
            st_d.vote_out = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RV_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign probe_rtck = st_q.vote_out;
    assign plain_tck  = st_q.vote_out;

    assert_rise_unanimous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(probe_rtck) |-> ($past(all_high) && $past(st_q.expect_lvl)));

    assert_fall_unanimous_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(probe_rtck) |-> ($past(all_low) && !$past(st_q.expect_lvl)));

    assert_hold_on_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_high && !all_low) |=> $stable(probe_rtck));

    assert_vote_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|dev_en) |-> !(all_high && all_low));

endmodule

// File: tb/rtck_voter_tb.sv
module rtck_voter_tb;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         probe_tck = 1'b0;
    logic [N-1:0] dev_en = '1;
    logic [N-1:0] dev_rtck = '0;
    logic [N-1:0] dev_tck;
    logic         probe_rtck;
    logic         plain_tck;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtck_voter #(.N_DEV(N), .SYNC_STAGES(2)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_tck  (probe_tck),
        .dev_en     (dev_en),
        .dev_rtck   (dev_rtck),
        .dev_tck    (dev_tck),
        .probe_rtck (probe_rtck),
        .plain_tck  (plain_tck)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        wait_clks(1);
        chk("R2 rtck after reset", {3'b0, probe_rtck}, 4'b0);
        chk("R2 plain after reset", {3'b0, plain_tck}, 4'b0);
        dev_rtck = 4'b1111;
        wait_clks(8);
        chk("R3 no rise while tck low", {3'b0, probe_rtck}, 4'b0);
        dev_rtck = 4'b0000;
        wait_clks(6);
    endtask

    task automatic t_fanout();
        probe_tck = 1'b1;
        #1;
        chk("R1 fan-out high", dev_tck, 4'b1111);
        probe_tck = 1'b0;
        #1;
        chk("R1 fan-out low", dev_tck, 4'b0000);
        wait_clks(6);
    endtask

    task automatic t_latency();
        dev_en = 4'b1111;
        probe_tck = 1'b1;
        dev_rtck = 4'b1111;
        wait_clks(1);
        chk("R9 unchanged after one edge", {3'b0, probe_rtck}, 4'b0);
        wait_clks(4);
        chk("R9 risen within five edges", {3'b0, probe_rtck}, 4'b1);
        chk("R7 plain follows combined", {3'b0, plain_tck}, 4'b1);
    endtask

    task automatic t_slow_fall();
        probe_tck = 1'b0;
        dev_rtck = 4'b0100;
        wait_clks(10);
        chk("R5 hold high while one lags", {3'b0, probe_rtck}, 4'b1);
        dev_rtck = 4'b0000;
        wait_clks(6);
        chk("R4 fall after all low", {3'b0, probe_rtck}, 4'b0);
        chk("R7 plain low", {3'b0, plain_tck}, 4'b0);
    endtask

    task automatic t_slow_rise();
        probe_tck = 1'b1;
        dev_rtck = 4'b0111;
        wait_clks(10);
        chk("R5 hold low while one lags", {3'b0, probe_rtck}, 4'b0);
        dev_rtck = 4'b1111;
        wait_clks(6);
        chk("R3 rise after all high", {3'b0, probe_rtck}, 4'b1);
        probe_tck = 1'b0;
        dev_rtck = 4'b0000;
        wait_clks(6);
    endtask

    task automatic t_masked();
        dev_en = 4'b0111;
        probe_tck = 1'b1;
        dev_rtck = 4'b0111;
        wait_clks(6);
        chk("R6 masked stuck-low ignored", {3'b0, probe_rtck}, 4'b1);
        probe_tck = 1'b0;
        dev_rtck = 4'b1000;
        wait_clks(6);
        chk("R6 masked stuck-high ignored", {3'b0, probe_rtck}, 4'b0);
        dev_rtck = 4'b0000;
        wait_clks(4);
    endtask

    task automatic t_empty();
        dev_en = 4'b0000;
        dev_rtck = 4'b1010;
        probe_tck = 1'b1;
        wait_clks(6);
        chk("R8 empty mask follows high", {3'b0, probe_rtck}, 4'b1);
        probe_tck = 1'b0;
        wait_clks(6);
        chk("R8 empty mask follows low", {3'b0, probe_rtck}, 4'b0);
        dev_en = 4'b1111;
        dev_rtck = 4'b0000;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clks(3);
        rst_n = 1'b1;
        t_reset();
        t_fanout();
        t_latency();
        t_slow_fall();
        t_slow_rise();
        t_masked();
        t_empty();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule